// File: doc/BRIEF.md
# Factory Bad-Block Marker Probe

This block decides whether one erase block of a NAND array carries a factory bad-block marker. A request names the block and selects one of two marker conventions. The block then asks a spare-area read engine for the spare bytes of one or two pages of that block. It inspects each byte as it arrives and gives a verdict: the block is bad, the block is clean, or a read failed.

The read engine sits outside this block. The block sends it a one-cycle request that carries an absolute page number. The engine answers in one of two ways: it streams the whole spare area of that page one byte per valid beat, with idle cycles allowed between beats, or it sends a single error pulse. The probe checks at most two pages. It asks for the second page only when the first one showed no marker, so a marked block costs a single spare-area read.

Two conventions are supported. In the legacy convention, only the first spare byte of the first page and of the page right after it is examined. In the full convention, every spare byte of the first page and of the last page of the block is examined.

Top module: `bad_block_probe`

## Requirements
- R1: The first requested page is `blk_i * PAGES_PER_BLK`, with `blk_i` sampled in the cycle the start is accepted. Every request on `rd_req_o` lasts exactly one cycle, and `rd_page_o` holds the page number during that cycle.
- R2: With `full_scan_i = 0` (legacy) and no marker on the first page, the second requested page is the first page plus 1.
- R3: In legacy mode a page counts as marked only when its spare byte 0 is 8'h00. Byte 0 is the first byte delivered after the request. A zero at any other byte position has no effect on the verdict.
- R4: With `full_scan_i = 1` (full) and no marker on the first page, the second requested page is the first page plus `PAGES_PER_BLK - 1`.
- R5: In full mode a page counts as marked when any of its `SPARE_BYTES` spare bytes is 8'h00. This includes the last byte.
- R6: When the first page is marked, the check ends with `bad_o = 1` and no second request is issued.
- R7: An `rd_err_i` pulse during a page transfer ends the check with `err_o = 1` and `bad_o = 0`, and no further page is requested. `bad_o` and `err_o` are never high together.
- R8: When neither page is marked, the check ends after exactly two requests with `bad_o = 0` and `err_o = 0`.
- R9: While `busy_o` is high, a start pulse and any change on `blk_i` or `full_scan_i` are ignored. The running check's pages and verdict stay as they would have been.
- R10: After reset, `busy_o`, `done_o`, `bad_o`, `err_o` and `rd_req_o` are 0. `busy_o` rises in the cycle after the start is accepted. `done_o` is a one-cycle pulse in the cycle after the final byte or the error is received, with `busy_o` still high. `busy_o` falls in the cycle after that. `bad_o` and `err_o` hold their values until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a check; accepted only while idle |
| blk_i | input | BLK_W | Erase block number to check |
| full_scan_i | input | 1 | 0: legacy convention, 1: full convention |
| rd_req_o | output | 1 | One-cycle spare-area read request |
| rd_page_o | output | PAGE_W | Absolute page number of the request |
| rd_vld_i | input | 1 | Spare byte valid |
| rd_data_i | input | 8 | Spare byte |
| rd_err_i | input | 1 | Spare-area read failed |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle verdict strobe |
| bad_o | output | 1 | Verdict: block is marked bad |
| err_o | output | 1 | Verdict: a read failed |

## Verification
The bench targets the following corner cases. In each case a likely defect would show up as follows:
- A zero in the very last spare byte of a page, in full mode. A counter that judges the page before including its final byte would call the block clean.
- A zero away from byte 0, in legacy mode. A design that applies the full-mode test to both conventions would wrongly call the block bad.
- The distance to the second page in each mode. Swapping the two steps, or using `PAGES_PER_BLK` instead of `PAGES_PER_BLK - 1`, sends the second request to the wrong page.
- A marker on the first page, and a read error. A design that keeps going would issue a second request or report a verdict together with the error.
- Start pulses, a different block number and a different mode, all applied in the middle of a check. A design that re-samples its inputs would change the second page or the verdict.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_COLLECT = 2'd2,
        ST_FIN     = 2'd3
    } probe_st_e;

    typedef enum logic {
        SCAN_LEGACY = 1'b0,
        SCAN_FULL   = 1'b1
    } scan_mode_e;

    // A spare byte signals a marker when it is zero and the convention
    // looks at its position.
    function automatic logic marker_hit(scan_mode_e mode, logic first_byte,
                                        logic [7:0] value);
        return (value == 8'h00) && ((mode == SCAN_FULL) || first_byte);
    endfunction

endpackage

// File: rtl/bbp_page_addr.sv
module bbp_page_addr
    import bbp_pkg::*;
#(
    parameter int BLK_W         = 10,
    parameter int PAGES_PER_BLK = 64,
    parameter int PAGE_W        = BLK_W + $clog2(PAGES_PER_BLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [BLK_W-1:0]  blk,
    input  scan_mode_e        mode,
    output logic [PAGE_W-1:0] page
);
    localparam logic [PAGE_W-1:0] PPB_W     = PAGE_W'(PAGES_PER_BLK);
    localparam logic [PAGE_W-1:0] STEP_FULL = PAGE_W'(PAGES_PER_BLK - 1);
    localparam logic [PAGE_W-1:0] STEP_LEG  = PAGE_W'(1);

    logic [PAGE_W-1:0] step;

    always_comb begin
        step = (mode == SCAN_FULL) ? STEP_FULL : STEP_LEG;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
        end else if (load) begin
            page <= PAGE_W'(blk) * PPB_W;
        end else if (advance) begin
            page <= page + step;
        end
    end

endmodule

// File: rtl/bbp_spare_eval.sv
module bbp_spare_eval
    import bbp_pkg::*;
#(
    parameter int SPARE_BYTES = 16,
    parameter int CNT_W       = $clog2(SPARE_BYTES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       vld,
    input  logic [7:0] data,
    input  scan_mode_e mode,
    output logic       page_end,
    output logic       page_bad
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SPARE_BYTES - 1);

    logic [CNT_W-1:0] cnt;
    logic             zero_q;
    logic             this_hit;

    always_comb begin
        this_hit = vld && marker_hit(mode, cnt == '0, data);
        page_end = vld && (cnt == LAST_IDX);
        page_bad = zero_q || this_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            zero_q <= 1'b0;
        end else if (vld) begin
            cnt    <= cnt + 1'b1;
            zero_q <= zero_q || this_hit;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_IDX + 1'b1); // R5

endmodule

// File: rtl/bbp_ctrl.sv
module bbp_ctrl
    import bbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       full_scan,
    input  logic       rd_err,
    input  logic       page_end,
    input  logic       page_bad,
    output logic       load,
    output logic       advance,
    output logic       clr,
    output scan_mode_e mode_q,
    output probe_st_e  st_q,
    output logic       bad_q,
    output logic       err_q
);
    probe_st_e st_d;
    logic      second_q;
    logic      finish_bad;
    logic      finish_clean;

    always_comb begin
        load         = (st_q == ST_IDLE) && start;
        clr          = (st_q == ST_REQ);
        finish_bad   = (st_q == ST_COLLECT) && !rd_err && page_end && page_bad;
        finish_clean = (st_q == ST_COLLECT) && !rd_err && page_end && !page_bad && second_q;
        advance      = (st_q == ST_COLLECT) && !rd_err && page_end && !page_bad && !second_q;
        st_d         = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = ST_REQ;
            ST_REQ:     st_d = ST_COLLECT;
            ST_COLLECT: begin
                if (rd_err || finish_bad || finish_clean) st_d = ST_FIN;
                else if (advance)                          st_d = ST_REQ;
            end
            ST_FIN:     st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mode_q   <= SCAN_LEGACY;
            second_q <= 1'b0;
            bad_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load) begin
                mode_q   <= scan_mode_e'(full_scan);
                second_q <= 1'b0;
                bad_q    <= 1'b0;
                err_q    <= 1'b0;
            end else begin
                if (advance)    second_q <= 1'b1;
                if (finish_bad) bad_q    <= 1'b1;
                if ((st_q == ST_COLLECT) && rd_err) err_q <= 1'b1;
            end
        end
    end

    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_COLLECT && rd_err) |=> (st_q == ST_FIN && err_q && !bad_q)); // R7

endmodule

// File: rtl/bad_block_probe.sv
module bad_block_probe
    import bbp_pkg::*;
#(
    parameter int BLK_W         = 10,
    parameter int PAGES_PER_BLK = 64,
    parameter int SPARE_BYTES   = 16,
    parameter int PAGE_W        = BLK_W + $clog2(PAGES_PER_BLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic              full_scan_i,
    output logic              rd_req_o,
    output logic [PAGE_W-1:0] rd_page_o,
    input  logic              rd_vld_i,
    input  logic [7:0]        rd_data_i,
    input  logic              rd_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bad_o,
    output logic              err_o
);
    logic       load;
    logic       advance;
    logic       clr;
    logic       page_end;
    logic       page_bad;
    scan_mode_e mode_q;
    probe_st_e  st_q;

    bbp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .full_scan (full_scan_i),
        .rd_err    (rd_err_i),
        .page_end  (page_end),
        .page_bad  (page_bad),
        .load      (load),
        .advance   (advance),
        .clr       (clr),
        .mode_q    (mode_q),
        .st_q      (st_q),
        .bad_q     (bad_o),
        .err_q     (err_o)
    );

    bbp_page_addr #(
        .BLK_W         (BLK_W),
        .PAGES_PER_BLK (PAGES_PER_BLK),
        .PAGE_W        (PAGE_W)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .blk     (blk_i),
        .mode    (mode_q),
        .page    (rd_page_o)
    );

    bbp_spare_eval #(
        .SPARE_BYTES (SPARE_BYTES)
    ) u_eval (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .vld      (rd_vld_i && (st_q == ST_COLLECT)),
        .data     (rd_data_i),
        .mode     (mode_q),
        .page_end (page_end),
        .page_bad (page_bad)
    );

    always_comb begin
        rd_req_o = (st_q == ST_REQ);
        busy_o   = (st_q != ST_IDLE);
        done_o   = (st_q == ST_FIN);
    end

    // Requests issued since the last accepted start
    logic [1:0] req_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            req_cnt <= '0;
        end else if (start_i && !busy_o) begin
            req_cnt <= '0;
        end else if (rd_req_o && req_cnt != 2'd3) begin
            req_cnt <= req_cnt + 1'b1;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o); // R1
    AST_TWO_PAGES_MAX: assert property (@(posedge clk) disable iff (rst)
        req_cnt <= 2'd2); // R8
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bad_o && err_o)); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o)); // R10

endmodule

// File: tb/test_bad_block_probe.sv
`timescale 1ns/1ps
module test_bad_block_probe;
    localparam int BLK_W  = 10;
    localparam int PPB    = 64;
    localparam int SPARE  = 16;
    localparam int PAGE_W = BLK_W + $clog2(PPB);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [BLK_W-1:0]  blk_i = '0;
    logic              full_scan_i = 1'b0;
    logic              rd_req_o;
    logic [PAGE_W-1:0] rd_page_o;
    logic              rd_vld_i = 1'b0;
    logic [7:0]        rd_data_i = 8'h00;
    logic              rd_err_i = 1'b0;
    logic              busy_o, done_o, bad_o, err_o;

    bad_block_probe #(.BLK_W(BLK_W), .PAGES_PER_BLK(PPB), .SPARE_BYTES(SPARE)) i_bad_block_probe (
        .clk(clk), .rst(rst), .start_i(start_i), .blk_i(blk_i), .full_scan_i(full_scan_i),
        .rd_req_o(rd_req_o), .rd_page_o(rd_page_o), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
        .rd_err_i(rd_err_i), .busy_o(busy_o), .done_o(done_o), .bad_o(bad_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Responder configuration
    int z_page0 = -1, z_byte0 = -1, z_page1 = -1, z_byte1 = -1, err_page = -1;
    bit gap_en = 0;
    int req_log[$];

    function automatic logic [7:0] byte_for(int pg, int k);
        if (pg == z_page0 && k == z_byte0) return 8'h00;
        if (pg == z_page1 && k == z_byte1) return 8'h00;
        return 8'h80 | 8'(k);
    endfunction

    int rs_state = 0, rs_page = 0, rs_k = 0, rs_wait = 0;
    bit gapped = 0;
    always @(negedge clk) begin
        rd_vld_i = 1'b0; rd_err_i = 1'b0; rd_data_i = 8'h00;
        if (rst) rs_state = 0;
        else begin
            case (rs_state)
                0: if (rd_req_o === 1'b1) begin
                    req_log.push_back(int'(rd_page_o));
                    rs_page = int'(rd_page_o); rs_wait = 2; rs_state = 1;
                end
                1: if (rs_wait == 0) begin
                    if (rs_page == err_page) begin rd_err_i = 1'b1; rs_state = 0; end
                    else begin rs_state = 2; rs_k = 0; gapped = 0; end
                end else rs_wait--;
                default: begin
                    if (gap_en && rs_k == 3 && !gapped) gapped = 1;
                    else begin
                        rd_vld_i = 1'b1; rd_data_i = byte_for(rs_page, rs_k);
                        rs_k++;
                        if (rs_k == SPARE) rs_state = 0;
                    end
                end
            endcase
        end
    end

    // Behavioural reference model, advanced on each rising edge
    int m_st = 0, m_page = 0, m_cnt = 0, m_pass = 0;
    bit m_mode = 0, m_zero = 0, m_bad = 0, m_err = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_page = 0; m_bad = 0; m_err = 0; m_mode = 0;
        end else begin
            case (m_st)
                0: if (start_i) begin
                    m_st = 1; m_page = int'(blk_i) * PPB; m_mode = full_scan_i;
                    m_pass = 0; m_bad = 0; m_err = 0;
                end
                1: begin m_st = 2; m_cnt = 0; m_zero = 0; end
                2: begin
                    if (rd_err_i) begin m_err = 1; m_st = 3; end
                    else if (rd_vld_i) begin
                        if (rd_data_i == 8'h00 && (m_mode || m_cnt == 0)) m_zero = 1;
                        if (m_cnt == SPARE - 1) begin
                            if (m_zero) begin m_bad = 1; m_st = 3; end
                            else if (m_pass == 1) m_st = 3;
                            else begin
                                m_pass = 1; m_page = m_page + (m_mode ? PPB - 1 : 1); m_st = 1;
                            end
                        end else m_cnt++;
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R10", "busy_o", int'(busy_o), int'(m_st != 0));
            chk("R10", "done_o", int'(done_o), int'(m_st == 3));
            chk("R1", "rd_req_o", int'(rd_req_o), int'(m_st == 1));
            if (m_st == 1) chk("R1", "rd_page_o", int'(rd_page_o), m_page);
            chk("R3", "bad_o", int'(bad_o), int'(m_bad));
            chk("R7", "err_o", int'(err_o), int'(m_err));
        end
    end

    // One check: start, optional interference, wait for done, compare verdict
    task automatic run(string req, int blk, bit mode, bit interfere,
                       int exp_bad, int exp_err, int exp_p0, int exp_p1);
        int cyc = 0;
        @(negedge clk);
        req_log.delete();
        start_i = 1'b1; blk_i = BLK_W'(blk); full_scan_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        while (done_o !== 1'b1 && cyc < 1000) begin
            if (interfere && cyc >= 3 && cyc < 6) begin
                start_i = 1'b1; blk_i = BLK_W'(blk + 7); full_scan_i = ~mode;
            end else start_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(req, "done reached", int'(done_o === 1'b1), 1);
        chk(req, "bad verdict", int'(bad_o), exp_bad);
        chk(req, "err verdict", int'(err_o), exp_err);
        chk(req, "request count", req_log.size(), (exp_p1 < 0) ? 1 : 2);
        if (req_log.size() > 0) chk(req, "first page", req_log[0], exp_p0);
        if (req_log.size() > 1 && exp_p1 >= 0) chk(req, "second page", req_log[1], exp_p1);
        @(negedge clk);
        chk("R10", "busy after done", int'(busy_o), 0);
        chk("R10", "verdict held", int'(bad_o), exp_bad);
    endtask

    task automatic clear_cfg();
        z_page0 = -1; z_byte0 = -1; z_page1 = -1; z_byte1 = -1; err_page = -1; gap_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "reset busy", int'(busy_o), 0);
        chk("R10", "reset done", int'(done_o), 0);
        chk("R10", "reset bad", int'(bad_o), 0);
        chk("R10", "reset err", int'(err_o), 0);
        chk("R10", "reset req", int'(rd_req_o), 0);

        // R2 R8: legacy, clean block
        clear_cfg(); gap_en = 1;
        run("R2", 3, 1'b0, 1'b0, 0, 0, 192, 193);
        // R3 R6: legacy, byte 0 of first page zero
        clear_cfg(); z_page0 = 320; z_byte0 = 0;
        run("R6", 5, 1'b0, 1'b0, 1, 0, 320, -1);
        // R3: legacy, zero at byte 5 of both pages is ignored
        clear_cfg(); z_page0 = 64; z_byte0 = 5; z_page1 = 65; z_byte1 = 5;
        run("R3", 1, 1'b0, 1'b0, 0, 0, 64, 65);
        // R3: legacy, byte 0 of second page zero
        clear_cfg(); z_page0 = 449; z_byte0 = 0;
        run("R3", 7, 1'b0, 1'b0, 1, 0, 448, 449);
        // R4 R8: full, clean block
        clear_cfg(); gap_en = 1;
        run("R4", 2, 1'b1, 1'b0, 0, 0, 128, 191);
        // R5: full, zero at byte 9 of last page
        clear_cfg(); z_page0 = 191; z_byte0 = 9;
        run("R5", 2, 1'b1, 1'b0, 1, 0, 128, 191);
        // R5 R6: full, zero in last spare byte of first page
        clear_cfg(); z_page0 = 256; z_byte0 = SPARE - 1;
        run("R5", 4, 1'b1, 1'b0, 1, 0, 256, -1);
        // R5: full, zero in a page between first and last is never read
        clear_cfg(); z_page0 = 257; z_byte0 = 0;
        run("R4", 4, 1'b1, 1'b0, 0, 0, 256, 319);
        // R7: error on first page
        clear_cfg(); err_page = 640;
        run("R7", 10, 1'b0, 1'b0, 0, 1, 640, -1);
        // R7: error on last page in full mode
        clear_cfg(); err_page = 703;
        run("R7", 10, 1'b1, 1'b0, 0, 1, 640, 703);
        // R9: start, block and mode changes while busy are ignored
        clear_cfg();
        run("R9", 6, 1'b0, 1'b1, 0, 0, 384, 385);
        clear_cfg(); z_page0 = 447; z_byte0 = 3;
        run("R9", 6, 1'b1, 1'b1, 1, 0, 384, 447);
        // R1: highest block number, full page width
        clear_cfg();
        run("R1", (1 << BLK_W) - 1, 1'b1, 1'b0, 0, 0, ((1 << BLK_W) - 1) * PPB,
            ((1 << BLK_W) - 1) * PPB + PPB - 1);
        // R10: bad verdict cleared by next clean check
        clear_cfg(); z_page0 = 0; z_byte0 = 0;
        run("R6", 0, 1'b0, 1'b0, 1, 0, 0, -1);
        clear_cfg();
        run("R10", 0, 1'b0, 1'b0, 0, 0, 0, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule